// File: doc/BRIEF.md
# Serial Result Transmitter for a Sampling Converter

This block takes each parallel result from a sampling converter and sends it out on one data line. It generates its own serial clock and a frame marker. The converter itself is not part of the block. It is represented by two pulses: one when a conversion starts and one when it finishes, and the finishing pulse carries the result word. A busy flag stays set from the start pulse until the result has been captured.

Four static configuration bits shape the transfer:

- **Read timing.** In the default mode a result is sent as soon as its conversion finishes, at a slow serial clock. In the alternative mode the block sends the previously captured result while the next conversion is running, using a shorter serial-clock period.
- **Output coding.** The word can be sent in straight binary or in two's complement.
- **Frame-marker polarity.** The frame marker can be active high or active low.
- **Clock inversion.** The serial clock can be inverted.

A host receiving the data samples it on the rising edge of the un-inverted serial clock.

Top module: `adc_serial_tx`

## Requirements
- R1: After reset the outputs idle as follows: `busy` low, `sdout` low, `sync` at its inactive level, and `sclk` at its idle level. The idle level of `sclk` is low when `cfg_sclk_inv`=0 and high when it is 1.
- R2: `busy` is high on the clock after a `conv_start` pulse. It goes low on the clock after a `conv_done` pulse, which is the edge that stores the result.
- R3: With `cfg_rdc`=0, a frame begins on the clock after `conv_done` and carries that same result. A frame is 16 serial clock periods, sent most significant bit first, each period DIV_RAC system clocks long. The frame lasts exactly 16*DIV_RAC clocks.
- R4: With `cfg_rdc`=1, a frame begins on the clock after `conv_start` and carries the result stored before that start. Its period is DIV_RDC clocks, so the frame lasts 16*DIV_RDC clocks. `conv_done` does not start a frame in this mode. The stored result is zero after reset.
- R5: With `cfg_twos`=1, the stored word is the input with bit 15 inverted. With `cfg_twos`=0 it is the input unchanged. The coding is fixed at the moment the result is stored.
- R6: `sync` is active for the whole frame and inactive otherwise. Active means high when `cfg_sync_inv`=0 and low when `cfg_sync_inv`=1.
- R7: `cfg_sclk_inv`=1 inverts `sclk` at all times, including while idle.
- R8: `sdout` is low whenever no frame is in progress.
- R9: A start condition that arrives while a frame is in progress is ignored. The frame in progress continues unchanged, and no extra frame follows it.
- R10: Within a frame, `sdout` changes only when the un-inverted serial clock goes low. It holds steady throughout the high half of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | One-cycle pulse that marks a conversion start |
| conv_done | input | 1 | One-cycle pulse that marks conversion completion |
| conv_data | input | 16 | Result in straight binary, valid with `conv_done` |
| cfg_sync_inv | input | 1 | 1 selects an active-low `sync` |
| cfg_sclk_inv | input | 1 | 1 inverts `sclk` |
| cfg_rdc | input | 1 | 1 sends the previous result while a conversion runs |
| cfg_twos | input | 1 | 1 selects two's-complement coding |
| sclk | output | 1 | Generated serial clock |
| sdout | output | 1 | Serial data, most significant bit first |
| sync | output | 1 | Frame marker |
| busy | output | 1 | Conversion in progress |

## Verification
A corrupted bit counter or period counter shows up as soon as the frame marker drops. The frame then has the wrong number of clock edges, or a length other than 16 times the divide. A wrong shift register or a wrong coding choice shows up as a mismatched word in the same frame. A stale stored result shows up one conversion later in read-during-convert mode, where the word from the previous conversion is sent. A missed or doubled start condition is caught after the frame in progress ends. The scoreboard then either finds a frame with no matching expected word, or is left holding an expected word that never arrives.

// File: rtl/adc_serial_tx.sv
module adc_serial_tx #(
  parameter int DATA_W  = 16,
  parameter int DIV_RAC = 8,
  parameter int DIV_RDC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              cfg_sync_inv,
  input  logic              cfg_sclk_inv,
  input  logic              cfg_rdc,
  input  logic              cfg_twos,
  output logic              sclk,
  output logic              sdout,
  output logic              sync,
  output logic              busy
);

  localparam int CW = $clog2(DIV_RAC + 1);
  localparam int BW = $clog2(DATA_W);

  logic [DATA_W-1:0] res_q, sh_q;
  logic [CW-1:0]     cnt_q, div_q;
  logic [BW-1:0]     bit_q;
  logic              active;
  logic              sclk_raw;
  logic [DATA_W-1:0] coded;
  logic              go_rac, go_rdc, last_tick;

  assign coded     = {conv_data[DATA_W-1] ^ cfg_twos, conv_data[DATA_W-2:0]};
  assign go_rac    = conv_done  && !cfg_rdc && !active;
  assign go_rdc    = conv_start &&  cfg_rdc && !active;
  assign last_tick = (cnt_q == div_q - CW'(1));

  assign sclk_raw = active && (cnt_q >= (div_q >> 1));
  assign sclk     = sclk_raw ^ cfg_sclk_inv;
  assign sdout    = active && sh_q[DATA_W-1];
  assign sync     = active ^ cfg_sync_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      res_q <= '0;
    end else begin
      if (conv_start) busy <= 1'b1;
      if (conv_done) begin
        busy  <= 1'b0;
        res_q <= coded;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      div_q  <= CW'(DIV_RAC);
      bit_q  <= '0;
    end else if (!active) begin
      if (go_rac || go_rdc) begin
        active <= 1'b1;
        sh_q   <= go_rac ? coded : res_q;
        div_q  <= go_rac ? CW'(DIV_RAC) : CW'(DIV_RDC);
        cnt_q  <= '0;
        bit_q  <= '0;
      end
    end else if (last_tick) begin
      cnt_q <= '0;
      sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      if (bit_q == BW'(DATA_W - 1)) active <= 1'b0;
      else bit_q <= bit_q + BW'(1);
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !conv_done) |=> busy);
  assert_busy_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done));
  assert_rac_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_rac |=> (sync != cfg_sync_inv));
  assert_frame_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(bit_q) == BW'(DATA_W - 1)));
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync == cfg_sync_inv) |-> !sdout);
  assert_stable_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_raw && $past(sclk_raw)) |-> $stable(sdout));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && cnt_q != '0) |-> (bit_q == $past(bit_q)));

endmodule

// File: tb/test_adc_serial_tx.sv
module test_adc_serial_tx;
  localparam int DIV_RAC = 8;
  localparam int DIV_RDC = 4;

  logic clk = 0, rst_n = 0;
  logic conv_start = 0, conv_done = 0;
  logic [15:0] conv_data = '0;
  logic s_inv = 0, k_inv = 0, rdc = 0, twos = 0;
  logic sclk, sdout, sync, busy;

  int n_chk = 0, n_fail = 0;
  logic [15:0] q_word[$];
  int          q_len[$];
  logic [15:0] prev_res = '0;

  always #5 clk = ~clk;

  adc_serial_tx #(.DATA_W(16), .DIV_RAC(DIV_RAC), .DIV_RDC(DIV_RDC)) i_adc_serial_tx (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
    .conv_data(conv_data), .cfg_sync_inv(s_inv), .cfg_sclk_inv(k_inv),
    .cfg_rdc(rdc), .cfg_twos(twos), .sclk(sclk), .sdout(sdout), .sync(sync), .busy(busy));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  logic on_p = 0, raw_p = 0, unstable = 0, sd_p = 0;
  logic [15:0] word = '0;
  int len = 0, nb = 0;
  always @(negedge clk) begin
    logic on, raw;
    on  = (sync !== s_inv);
    raw = sclk ^ k_inv;
    if (on) begin
      len++;
      if (raw && !raw_p) begin
        word = {word[14:0], sdout};
        nb++;
      end
      if (raw && raw_p && sdout !== sd_p) unstable = 1;
    end else if (rst_n) begin
      n_chk++;
      if (sdout !== 1'b0) begin
        n_fail++;
        $display("FAIL R8 idle sdout actual=%0b expected=0", sdout);
      end
    end
    if (!on && on_p) begin
      if (q_word.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9 unexpected frame actual=%0h expected=none", word);
      end else begin
        logic [15:0] ew; int el; string rq;
        ew = q_word.pop_front(); el = q_len.pop_front();
        rq = (el == 16*DIV_RDC) ? "R4" : "R3";
        check({rq, " word"}, word, ew);
        check({rq, " length"}, len, el);
        check({rq, " bits"}, nb, 16);
        check("R10 stable high half", unstable, 0);
      end
      len = 0; nb = 0; word = '0; unstable = 0;
    end
    on_p = on; raw_p = raw; sd_p = sdout;
  end

  function automatic logic [15:0] code(input logic [15:0] d);
    return {d[15] ^ twos, d[14:0]};
  endfunction

  task automatic pulse_start(input bit push);
    @(negedge clk) conv_start = 1;
    if (push && rdc) begin q_word.push_back(prev_res); q_len.push_back(16*DIV_RDC); end
    @(negedge clk) conv_start = 0;
    check("R2 busy rise", busy, 1);
  endtask

  task automatic pulse_done(input logic [15:0] d);
    @(negedge clk) begin conv_done = 1; conv_data = d; end
    if (!rdc) begin q_word.push_back(code(d)); q_len.push_back(16*DIV_RAC); end
    prev_res = code(d);
    @(negedge clk) conv_done = 0;
    check("R2 busy fall", busy, 0);
  endtask

  task automatic convert(input logic [15:0] d);
    pulse_start(1);
    repeat (5) @(negedge clk);
    pulse_done(d);
    wait (q_word.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 sdout", sdout, 0);
    check("R1 sync", sync, 0);
    check("R1 sclk", sclk, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    convert(16'hA5C3);
    convert(16'h0001);
    convert(16'hFFFF);
    twos = 1;
    convert(16'h8000); // R5: expect 0000
    convert(16'h1234); // R5: expect 9234
    twos = 0;
    s_inv = 1;
    @(negedge clk) check("R6 idle sync inverted", sync, 1);
    convert(16'h5A5A);
    k_inv = 1;
    @(negedge clk) check("R7 idle sclk inverted", sclk, 1);
    convert(16'h3C0F);
    s_inv = 0; k_inv = 0;

    rdc = 1;
    convert(16'h7E81);   // R4 sends 3C0F
    twos = 1;
    convert(16'h0F0F);   // R4 sends 7E81, stores 8F0F
    twos = 0;
    // R9: a second start during the frame is ignored
    pulse_start(1);
    repeat (10) @(negedge clk);
    pulse_start(0);
    repeat (3) @(negedge clk);
    pulse_done(16'hC001);
    wait (q_word.size() == 0);
    repeat (100) @(negedge clk);
    check("R9 queue drained", q_word.size(), 0);
    // R4: conv_done alone starts no frame in this mode
    pulse_done(16'h2222);
    repeat (100) @(negedge clk);
    convert(16'h0000);   // sends 2222
    rdc = 0;
    convert(16'h8001);
    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule